// File: doc/BRIEF.md
# Sequential Shift-Add Multiplier

This block multiplies two unsigned WIDTH-bit numbers one bit at a time. A small datapath does the arithmetic: a multiplicand register, a multiplier shift register, an accumulator, a carry flip-flop and an iteration down-counter. A three-state controller drives it. The controller keeps its state in a two-bit encoded register with the codes idle = 00, add = 01 and shift = 10. A decoder turns that register into one line per state, and a short table of equations built from those lines produces every control strobe.

Both operands arrive on one shared bus, and each has its own load strobe. After loading, the user raises `go`. Each bit of the multiplier then takes two clock cycles. In the add cycle, the multiplicand is added to the accumulator if the lowest multiplier bit is 1, and the carry-out is kept. In the shift cycle, carry, accumulator and multiplier move right together by one place, and the iteration counter counts down. When the counter reaches zero, the controller returns to idle and `done` pulses. The 2·WIDTH-bit result is the accumulator placed above the multiplier register.

Top module: `shift_add_mult`

## Requirements
- R1: While `rst` is high at a rising edge, the block goes to idle. After that edge `busy` = 0, `done` = 0 and `product` = 0.
- R2: In idle, `load_mcand` loads `operand_in` as the multiplicand and `load_mplier` loads it as the multiplier. When both strobes are high in the same cycle, only the multiplicand loads and the multiplier keeps its value.
- R3: When `done` pulses, `product` equals the unsigned product of the loaded multiplicand and multiplier, with the upper WIDTH bits in `product[2*WIDTH-1:WIDTH]`. This holds for every pair of operand values.
- R4: `done` rises on exactly the 2·WIDTH-th rising edge after the edge that samples `go` high in idle.
- R5: `busy` is 1 from the edge that samples `go` until the edge that raises `done`. It is 0 while `done` is high. `done` stays high for exactly one cycle.
- R6: While `busy` is 1, both load strobes are ignored. Pulsing them during a run does not change that run's result.
- R7: While `busy` is 1, `go` is ignored. A second `go` during a run changes neither the latency nor the result.
- R8: In idle, `product` is the accumulator placed above the multiplier register. A multiplier loaded after reset therefore appears in `product[WIDTH-1:0]` on the next cycle. A finished result stays unchanged while the block remains idle and nothing is loaded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| go | input | 1 | Starts a multiplication when sampled high in idle |
| load_mcand | input | 1 | Loads the multiplicand from `operand_in` (idle only; has priority) |
| load_mplier | input | 1 | Loads the multiplier from `operand_in` (idle only) |
| operand_in | input | WIDTH | Shared operand bus |
| product | output | 2*WIDTH | Accumulator above multiplier register |
| busy | output | 1 | High while a multiplication is in progress |
| done | output | 1 | One-cycle pulse when the result is ready |

## Verification
Almost every internal fault reaches `product` within one run, because each wrong bit of the accumulator, carry or multiplier register is shifted into the result. An add that is skipped or doubled, a carry that is lost, or a shift that fills with the wrong bit gives a wrong result when `done` pulses. A wrong counter load or zero-detect changes how long the run takes, so `done` arrives early or late by a multiple of two cycles. A controller that decodes idle wrongly shows as a load strobe or a repeated `go` that corrupts the result or restarts the count during a run.

// File: rtl/mul_pkg.sv
package mul_pkg;
  // Controller state codes; the next-state equations depend on these exact values.
  typedef enum logic [1:0] {
    ST_IDLE  = 2'b00,
    ST_ADD   = 2'b01,
    ST_SHIFT = 2'b10
  } ctl_state_e;

  localparam int STATE_W   = 2;
  localparam int STATE_NUM = 3;
endpackage

// File: rtl/state_decode.sv
module state_decode #(
  parameter int CODE_W = 2,
  parameter int LINES  = 3
) (
  input  logic [CODE_W-1:0] code,
  output logic [LINES-1:0]  line
);
  for (genvar i = 0; i < LINES; i++) begin : g_line
    assign line[i] = (code == CODE_W'(i));
  end
endmodule

// File: rtl/mul_ctrl.sv
module mul_ctrl
  import mul_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic go,
  input  logic q_lsb,
  input  logic cnt_zero,
  output logic idle,
  output logic init_en,
  output logic add_en,
  output logic clr_carry,
  output logic shift_en,
  output logic busy,
  output logic done
);
  logic [STATE_W-1:0]   st_q, st_d;
  logic [STATE_NUM-1:0] line;
  logic                 busy_q, done_q;

  state_decode #(.CODE_W(STATE_W), .LINES(STATE_NUM)) u_dec (
    .code (st_q),
    .line (line)
  );

  // Decoded state lines; an unused code drives none, so it falls back to idle.
  assign idle = line[ST_IDLE];

  // Control equations
  assign init_en   = line[ST_IDLE] & go;
  assign add_en    = line[ST_ADD] & q_lsb;
  assign clr_carry = (line[ST_IDLE] & go) | line[ST_SHIFT];
  assign shift_en  = line[ST_SHIFT];

  // Next-state equations: high bit from the add line, low bit from start or loop-back
  assign st_d = {line[ST_ADD], (line[ST_IDLE] & go) | (line[ST_SHIFT] & ~cnt_zero)};

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_IDLE;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      busy_q <= |st_d;
      done_q <= line[ST_SHIFT] & cnt_zero;
    end
  end

  assign busy = busy_q;
  assign done = done_q;

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R5
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy); // R5
  AST_GO_SETS_BUSY: assert property (@(posedge clk) disable iff (rst)
    (idle && go) |=> busy); // R5
  AST_ADD_THEN_SHIFT: assert property (@(posedge clk) disable iff (rst)
    line[ST_ADD] |=> line[ST_SHIFT]); // R4
  AST_GO_IGNORED_BUSY: assert property (@(posedge clk) disable iff (rst)
    (line[ST_ADD] && go) |=> !idle); // R7
endmodule

// File: rtl/mul_datapath.sv
module mul_datapath #(
  parameter int WIDTH = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               idle,
  input  logic               ld_mcand_req,
  input  logic               ld_mplier_req,
  input  logic [WIDTH-1:0]   operand_in,
  input  logic               init_en,
  input  logic               add_en,
  input  logic               clr_carry,
  input  logic               shift_en,
  output logic               q_lsb,
  output logic               cnt_zero,
  output logic [2*WIDTH-1:0] product
);
  localparam int CNT_W = $clog2(WIDTH);

  logic [WIDTH-1:0] mcand_q, mplier_q, acc_q;
  logic             carry_q;
  logic [CNT_W-1:0] cnt_q;
  logic [WIDTH:0]   sum;
  logic             ld_mcand, ld_mplier;

  assign ld_mcand  = idle & ld_mcand_req;
  assign ld_mplier = idle & ld_mplier_req & ~ld_mcand_req;
  assign sum       = {1'b0, acc_q} + {1'b0, mcand_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      mcand_q  <= '0;
      mplier_q <= '0;
      acc_q    <= '0;
      carry_q  <= 1'b0;
      cnt_q    <= '0;
    end else begin
      if (ld_mcand) mcand_q <= operand_in;

      if (shift_en)       mplier_q <= {acc_q[0], mplier_q[WIDTH-1:1]};
      else if (ld_mplier) mplier_q <= operand_in;

      if (init_en)       acc_q <= '0;
      else if (add_en)   acc_q <= sum[WIDTH-1:0];
      else if (shift_en) acc_q <= {carry_q, acc_q[WIDTH-1:1]};

      if (add_en)         carry_q <= sum[WIDTH];
      else if (clr_carry) carry_q <= 1'b0;

      if (init_en)       cnt_q <= CNT_W'(WIDTH - 1);
      else if (shift_en) cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  assign q_lsb    = mplier_q[0];
  assign cnt_zero = (cnt_q == '0);
  assign product  = {acc_q, mplier_q};

  AST_BOTH_STROBES_KEEP_MPLIER: assert property (@(posedge clk) disable iff (rst)
    (idle && ld_mcand_req && ld_mplier_req && !shift_en) |=> $stable(mplier_q)); // R2
  AST_MCAND_HELD_BUSY: assert property (@(posedge clk) disable iff (rst)
    !idle |=> $stable(mcand_q)); // R6
  AST_SHIFT_ZERO_FILL: assert property (@(posedge clk) disable iff (rst)
    shift_en |=> !carry_q); // R3
  AST_COUNT_DOWN: assert property (@(posedge clk) disable iff (rst)
    (shift_en && !cnt_zero) |=> (cnt_q == $past(cnt_q) - CNT_W'(1))); // R4
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (idle && !init_en && !ld_mcand_req && !ld_mplier_req) |=> $stable(product)); // R8
endmodule

// File: rtl/shift_add_mult.sv
module shift_add_mult #(
  parameter int WIDTH = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               go,
  input  logic               load_mcand,
  input  logic               load_mplier,
  input  logic [WIDTH-1:0]   operand_in,
  output logic [2*WIDTH-1:0] product,
  output logic               busy,
  output logic               done
);
  logic idle, init_en, add_en, clr_carry, shift_en, q_lsb, cnt_zero;

  mul_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .go        (go),
    .q_lsb     (q_lsb),
    .cnt_zero  (cnt_zero),
    .idle      (idle),
    .init_en   (init_en),
    .add_en    (add_en),
    .clr_carry (clr_carry),
    .shift_en  (shift_en),
    .busy      (busy),
    .done      (done)
  );

  mul_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk           (clk),
    .rst           (rst),
    .idle          (idle),
    .ld_mcand_req  (load_mcand),
    .ld_mplier_req (load_mplier),
    .operand_in    (operand_in),
    .init_en       (init_en),
    .add_en        (add_en),
    .clr_carry     (clr_carry),
    .shift_en      (shift_en),
    .q_lsb         (q_lsb),
    .cnt_zero      (cnt_zero),
    .product       (product)
  );
endmodule

// File: tb/tb_shift_add_mult.sv
module tb_shift_add_mult;
  localparam int W = 4;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           go = 1'b0;
  logic           load_mcand = 1'b0;
  logic           load_mplier = 1'b0;
  logic [W-1:0]   operand_in = '0;
  logic [2*W-1:0] product;
  logic           busy, done;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  shift_add_mult #(.WIDTH(W)) dut (
    .clk(clk), .rst(rst), .go(go), .load_mcand(load_mcand),
    .load_mplier(load_mplier), .operand_in(operand_in),
    .product(product), .busy(busy), .done(done)
  );

  always #2 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      fails = fails + 1;
      $display("FAIL R4 watchdog expired: actual %0d cycles, expected < 150000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic load_ops(input logic [W-1:0] a, input logic [W-1:0] b);
    @(negedge clk); load_mcand = 1'b1; operand_in = a;
    @(negedge clk); load_mcand = 1'b0; load_mplier = 1'b1; operand_in = b;
    @(negedge clk); load_mplier = 1'b0;
  endtask

  // mode 0: clean run, 1: load strobes during run (R6), 2: extra go during run (R7)
  task automatic run_op(input logic [2*W-1:0] exp, input int mode, input string tag);
    int cyc;
    logic [2*W-1:0] res;
    @(negedge clk); go = 1'b1;
    @(negedge clk); go = 1'b0; cyc = 1;
    chk(busy == 1'b1, "R5 busy after go", busy, 1);
    while (!done && cyc < 8*W) begin
      if (mode == 1 && cyc == 3) begin
        load_mcand = 1'b1; load_mplier = 1'b1; operand_in = '1;
      end
      if (mode == 1 && cyc == 5) begin
        load_mcand = 1'b0; load_mplier = 1'b0;
      end
      if (mode == 2 && cyc == 2) go = 1'b1;
      if (mode == 2 && cyc == 3) go = 1'b0;
      @(negedge clk); cyc++;
    end
    // done rises on the 2W-th edge after the go edge; seen 2W+1 negedges after go was driven
    chk(cyc == 2*W + 1, "R4 latency", cyc, 2*W + 1);
    chk(product == exp, tag, product, exp);
    chk(busy == 1'b0, "R5 busy low with done", busy, 0);
    res = product;
    @(negedge clk);
    chk(done == 1'b0, "R5 done one cycle", done, 0);
    chk(product == res, "R8 result held", product, res);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk(busy == 1'b0, "R1 busy at reset", busy, 0);
    chk(done == 1'b0, "R1 done at reset", done, 0);
    chk(product == '0, "R1 product at reset", product, 0);

    // R8 multiplier visible in low half in idle
    @(negedge clk); load_mplier = 1'b1; operand_in = 4'hA;
    @(negedge clk); load_mplier = 1'b0;
    chk(product == 8'h0A, "R8 idle view", product, 8'h0A);

    // R3 exhaustive sweep
    for (int a = 0; a < (1 << W); a++) begin
      for (int b = 0; b < (1 << W); b++) begin
        load_ops(W'(a), W'(b));
        run_op((2*W)'(a * b), 0, "R3 product");
      end
    end

    // R2 priority of multiplicand strobe
    load_ops(4'd2, 4'd3);
    @(negedge clk); load_mcand = 1'b1; load_mplier = 1'b1; operand_in = 4'd7;
    @(negedge clk); load_mcand = 1'b0; load_mplier = 1'b0;
    run_op(8'd21, 0, "R2 strobe priority");

    // R6 loads ignored while busy
    load_ops(4'd9, 4'd6);
    run_op(8'd54, 1, "R6 loads ignored");
    load_ops(4'd15, 4'd15);
    run_op(8'd225, 1, "R6 loads ignored max");

    // R7 go ignored while busy
    load_ops(4'd13, 4'd11);
    run_op(8'd143, 2, "R7 go ignored");

    // R8 hold over idle cycles
    repeat (5) @(negedge clk);
    chk(product == 8'd143, "R8 long hold", product, 143);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule